// File: doc/BRIEF.md
# UART Baud Generator with Timer Mode

This block derives the bit-rate timing for a serial port from the system clock. A divisor is assembled from two byte-wide registers, and a down-counter reloads from that divisor to produce a regular one-cycle enable. In the normal serial mode the enable is the 16x sample strobe, and a prescaler divides it by sixteen to give the bit strobe. In LIN mode the prescaler is bypassed, so the bit strobe runs at the full reload rate.

When the receiver is switched off and the timer-select input is high, the same counter also acts as a general reload timer. Every reload then sets a sticky interrupt flag, which stays set until a clear strobe removes it. The strobes keep running in this mode, so a transmitter attached to them can carry on sending.

Top module: `uart_rate_gen`

## Requirements
- R1: The divisor is `{high byte, low byte}`. A cycle with `div_hi_wr` high loads `wr_data` into bits 15:8, and a cycle with `div_lo_wr` high loads it into bits 7:0. After reset the divisor is the parameter `RESET_DIV` (default 4).
- R2: `sample_tick` is a one-cycle pulse that repeats every D clock cycles, where D is the divisor value loaded at the last reload. With D = 1 it is high on every cycle.
- R3: A divisor of 0 gives a reload period of 65536 cycles.
- R4: When `lin_mode` is 0, `bit_tick` pulses once for every 16 `sample_tick` pulses (period 16·D), and it is high only in a cycle where `sample_tick` is also high.
- R5: When `lin_mode` is 1, `bit_tick` is high in exactly the cycles where `sample_tick` is high (period D).
- R6: A divisor write does not restart the count in progress. The interval that is running keeps its old length, and the new value governs from the next reload.
- R7: When `rx_enable` is 0 and `timer_sel` is 1, each reload sets `timer_irq` in the same cycle that `sample_tick` pulses. With `rx_enable` 1 or `timer_sel` 0, reloads leave `timer_irq` at 0.
- R8: `timer_irq` stays high until a one-cycle `irq_clear`, which drops it in the following cycle. This holds even when a reload falls on the same edge as the clear.
- R9: In timer mode `sample_tick` keeps its period D, so transmit timing carries on.
- R10: During and just after reset, `sample_tick`, `bit_tick` and `timer_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_hi_wr | input | 1 | Load strobe for the divisor high byte |
| div_lo_wr | input | 1 | Load strobe for the divisor low byte |
| wr_data | input | 8 | Byte written by either strobe |
| rx_enable | input | 1 | Receiver enable; 0 permits timer mode |
| timer_sel | input | 1 | Selects timer mode while the receiver is off |
| lin_mode | input | 1 | 1 bypasses the divide-by-16 stage |
| irq_clear | input | 1 | One-cycle clear of the timer interrupt |
| sample_tick | output | 1 | One-cycle pulse per reload (16x enable) |
| bit_tick | output | 1 | One-cycle bit-rate enable |
| timer_irq | output | 1 | Sticky timer interrupt flag |

## Verification
Each strobe comes from a register. A reload decided at clock edge k therefore shows up on `sample_tick`, `bit_tick` and `timer_irq` in the cycle after edge k, and a clear applied before edge k shows up as a low flag in that same cycle. The checks sample every output at the falling edge and measure periods by counting falling edges between pulses, so they do not depend on the counter's phase. A divisor write is applied at the falling edge where a pulse is seen. That places the write inside an interval and proves that the running interval keeps its length and the next interval takes the new one.

// File: rtl/rate_gen_pkg.sv
package rate_gen_pkg;

   typedef struct packed {
      logic lin;       // bypass the oversampling prescaler
      logic timer_on;  // reloads raise the timer interrupt
   } rg_mode_t;

   function automatic rg_mode_t rg_decode(input logic rx_en, input logic tsel, input logic lin);
      rg_mode_t m;
      m.lin      = lin;
      m.timer_on = tsel & ~rx_en;
      return m;
   endfunction

endpackage

// File: rtl/rate_div_regs.sv
module rate_div_regs #(
   parameter int DIV_W     = 16,
   parameter int RESET_DIV = 4,
   localparam int BYTE_W   = DIV_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hi_wr,
   input  logic              lo_wr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [DIV_W-1:0]  divisor
);
   localparam logic [DIV_W-1:0] RST_VAL = DIV_W'(RESET_DIV);

   logic [BYTE_W-1:0] hi_q, lo_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q <= RST_VAL[DIV_W-1:BYTE_W];
         lo_q <= RST_VAL[BYTE_W-1:0];
      end else begin
         if (hi_wr) hi_q <= wr_data;
         if (lo_wr) lo_q <= wr_data;
      end
   end

   assign divisor = {hi_q, lo_q};
endmodule

// File: rtl/rate_down_counter.sv
module rate_down_counter #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] divisor,
   output logic             reload
);
   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   logic [DIV_W-1:0] cnt_q;

   // A loaded 0 wraps through all ones, which gives a 2**DIV_W period.
   assign reload = (cnt_q == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= ONE;
      else if (reload) cnt_q <= divisor;
      else             cnt_q <= cnt_q - ONE;
   end
endmodule

// File: rtl/rate_prescale.sv
module rate_prescale #(
   parameter int OVERSAMPLE = 16,
   localparam int PRE_W     = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic reload,
   input  logic lin,
   output logic sample_tick,
   output logic bit_tick
);
   logic sample_q, bit_q;

   generate
      if (OVERSAMPLE > 1) begin : g_div
         localparam logic [PRE_W-1:0] LAST = PRE_W'(OVERSAMPLE - 1);
         logic [PRE_W-1:0] pre_q;
         always_ff @(posedge clk) begin
            if (!rst_n || lin) pre_q <= '0;
            else if (reload)   pre_q <= pre_q + PRE_W'(1);
         end
         always_ff @(posedge clk) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= reload & (lin | (pre_q == LAST));
         end
      end else begin : g_nodiv
         always_ff @(posedge clk) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= reload;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) sample_q <= 1'b0;
      else        sample_q <= reload;
   end

   assign sample_tick = sample_q;
   assign bit_tick    = bit_q;
endmodule

// File: rtl/rate_irq.sv
module rate_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic reload,
   input  logic timer_on,
   input  logic clear,
   output logic irq
);
   logic irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                  irq_q <= 1'b0;
      else if (clear)              irq_q <= 1'b0;   // clear wins over a coincident reload
      else if (reload && timer_on) irq_q <= 1'b1;
   end

   assign irq = irq_q;
endmodule

// File: rtl/uart_rate_gen.sv
module uart_rate_gen
   import rate_gen_pkg::*;
#(
   parameter int DIV_W      = 16,
   parameter int OVERSAMPLE = 16,
   parameter int RESET_DIV  = 4,
   localparam int BYTE_W    = DIV_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              div_hi_wr,
   input  logic              div_lo_wr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              rx_enable,
   input  logic              timer_sel,
   input  logic              lin_mode,
   input  logic              irq_clear,
   output logic              sample_tick,
   output logic              bit_tick,
   output logic              timer_irq
);
   generate
      if (DIV_W < 2 || (DIV_W % 2) != 0) begin : g_bad_width
         $error("DIV_W must be even and at least 2");
      end
      if (OVERSAMPLE < 1 || (OVERSAMPLE & (OVERSAMPLE - 1)) != 0) begin : g_bad_os
         $error("OVERSAMPLE must be a power of two");
      end
      if (RESET_DIV < 0 || RESET_DIV >= (1 << DIV_W)) begin : g_bad_rst
         $error("RESET_DIV does not fit DIV_W");
      end
   endgenerate

   rg_mode_t         mode;
   logic [DIV_W-1:0] divisor;
   logic             reload;

   assign mode = rg_decode(rx_enable, timer_sel, lin_mode);

   rate_div_regs #(.DIV_W(DIV_W), .RESET_DIV(RESET_DIV)) u_regs (
      .clk(clk), .rst_n(rst_n), .hi_wr(div_hi_wr), .lo_wr(div_lo_wr),
      .wr_data(wr_data), .divisor(divisor)
   );

   rate_down_counter #(.DIV_W(DIV_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .divisor(divisor), .reload(reload)
   );

   rate_prescale #(.OVERSAMPLE(OVERSAMPLE)) u_pre (
      .clk(clk), .rst_n(rst_n), .reload(reload), .lin(mode.lin),
      .sample_tick(sample_tick), .bit_tick(bit_tick)
   );

   rate_irq u_irq (
      .clk(clk), .rst_n(rst_n), .reload(reload), .timer_on(mode.timer_on),
      .clear(irq_clear), .irq(timer_irq)
   );
endmodule

// File: rtl/rate_gen_checker.sv
module rate_gen_checker (
   input logic clk,
   input logic rst_n,
   input logic rx_enable,
   input logic timer_sel,
   input logic lin_mode,
   input logic irq_clear,
   input logic sample_tick,
   input logic bit_tick,
   input logic timer_irq
);
   assert_bit_in_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |-> sample_tick);

   assert_lin_bit_each_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_tick && $past(lin_mode)) |-> bit_tick);

   assert_irq_from_timer_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timer_irq) |-> (sample_tick && $past(!rx_enable && timer_sel)));

   assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (timer_irq && !irq_clear) |=> timer_irq);

   assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clear |=> !timer_irq);
endmodule

bind uart_rate_gen rate_gen_checker u_rate_gen_chk (
   .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .timer_sel(timer_sel),
   .lin_mode(lin_mode), .irq_clear(irq_clear), .sample_tick(sample_tick),
   .bit_tick(bit_tick), .timer_irq(timer_irq)
);

// File: tb/uart_rate_gen_bench.sv
module uart_rate_gen_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       div_hi_wr = 1'b0, div_lo_wr = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rx_enable = 1'b1, timer_sel = 1'b0, lin_mode = 1'b0, irq_clear = 1'b0;
   logic       sample_tick, bit_tick, timer_irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   uart_rate_gen u_uart_rate_gen (
      .clk(clk), .rst_n(rst_n), .div_hi_wr(div_hi_wr), .div_lo_wr(div_lo_wr),
      .wr_data(wr_data), .rx_enable(rx_enable), .timer_sel(timer_sel),
      .lin_mode(lin_mode), .irq_clear(irq_clear), .sample_tick(sample_tick),
      .bit_tick(bit_tick), .timer_irq(timer_irq)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Count falling edges until the chosen strobe is seen high (sel 0 sample, 1 bit).
   task automatic next_pulse(input bit sel, output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!(sel ? bit_tick : sample_tick) && n < 70000);
   endtask

   task automatic write_div(input logic [15:0] v);
      @(negedge clk); div_hi_wr = 1'b1; wr_data = v[15:8];
      @(negedge clk); div_hi_wr = 1'b0; div_lo_wr = 1'b1; wr_data = v[7:0];
      @(negedge clk); div_lo_wr = 1'b0;
   endtask

   // Program a divisor, let the old interval run out, return the settled period.
   task automatic settle_period(input logic [15:0] v, output int per);
      int n;
      write_div(v);
      next_pulse(1'b0, n);
      next_pulse(1'b0, n);
      next_pulse(1'b0, per);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      check("R10 sample_tick in reset", int'(sample_tick), 0);
      check("R10 bit_tick in reset", int'(bit_tick), 0);
      check("R10 timer_irq in reset", int'(timer_irq), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 timer_irq after reset", int'(timer_irq), 0);
   endtask

   task automatic t_reset_div;
      int n, per;
      next_pulse(1'b0, n);
      next_pulse(1'b0, per);
      check("R1 reset divisor period", per, 4);
   endtask

   task automatic t_periods;
      int per;
      settle_period(16'd7, per);
      check("R2 period D=7", per, 7);
      settle_period(16'd1, per);
      check("R2 period D=1", per, 1);
      settle_period(16'h0102, per);
      check("R1 high and low bytes D=258", per, 258);
   endtask

   task automatic t_normal_bit;
      int n, per, cnt;
      lin_mode = 1'b0;
      settle_period(16'd3, per);
      next_pulse(1'b1, n);
      next_pulse(1'b1, per);
      check("R4 bit period 16*D", per, 48);
      cnt = 0;
      for (int i = 0; i < 48; i++) begin
         @(negedge clk);
         if (sample_tick) cnt++;
         if (bit_tick && !sample_tick) cnt = -100;
      end
      check("R4 sample pulses per bit", cnt, 16);
   endtask

   task automatic t_lin;
      int n, per, mism;
      lin_mode = 1'b1;
      settle_period(16'd5, per);
      next_pulse(1'b1, n);
      next_pulse(1'b1, per);
      check("R5 LIN bit period D", per, 5);
      mism = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (bit_tick != sample_tick) mism++;
      end
      check("R5 bit equals sample", mism, 0);
      lin_mode = 1'b0;
   endtask

   task automatic t_no_restart;
      int per, n;
      settle_period(16'd10, per);
      // this falling edge is a pulse cycle: write low byte 3 inside the interval
      n = 0;
      div_lo_wr = 1'b1; wr_data = 8'd3;
      do begin
         @(negedge clk);
         n++;
         div_lo_wr = 1'b0;
      end while (!sample_tick && n < 100);
      check("R6 running interval keeps old length", n, 10);
      next_pulse(1'b0, per);
      check("R6 next interval uses new divisor", per, 3);
   endtask

   task automatic t_timer;
      int n, per, seen;
      settle_period(16'd6, per);
      rx_enable = 1'b1; timer_sel = 1'b1;
      seen = 0;
      for (int i = 0; i < 30; i++) begin @(negedge clk); if (timer_irq) seen++; end
      check("R7 receiver on blocks irq", seen, 0);
      rx_enable = 1'b0; timer_sel = 1'b0;
      for (int i = 0; i < 30; i++) begin @(negedge clk); if (timer_irq) seen++; end
      check("R7 timer_sel off blocks irq", seen, 0);
      timer_sel = 1'b1;
      next_pulse(1'b0, n);
      next_pulse(1'b0, n);
      check("R7 irq set with reload pulse", int'(timer_irq), 1);
      next_pulse(1'b0, per);
      check("R9 tick period in timer mode", per, 6);
      repeat (3) @(negedge clk);
      check("R8 irq sticky", int'(timer_irq), 1);
      irq_clear = 1'b1;
      @(negedge clk);
      irq_clear = 1'b0;
      check("R8 irq cleared", int'(timer_irq), 0);
   endtask

   task automatic t_clear_priority;
      int per;
      settle_period(16'd1, per);
      check("R8 reload every cycle", int'(timer_irq), 1);
      irq_clear = 1'b1;
      @(negedge clk);
      irq_clear = 1'b0;
      check("R8 clear beats coincident reload", int'(timer_irq), 0);
      @(negedge clk);
      check("R8 next reload sets again", int'(timer_irq), 1);
      timer_sel = 1'b0; rx_enable = 1'b1;
      irq_clear = 1'b1;
      @(negedge clk);
      irq_clear = 1'b0;
   endtask

   task automatic t_zero_div;
      int per;
      settle_period(16'd2, per);
      write_div(16'd0);
      next_pulse(1'b0, per);
      next_pulse(1'b0, per);
      check("R3 divisor 0 gives 65536", per, 65536);
   endtask

   initial begin
      t_reset();
      t_reset_div();
      t_periods();
      t_normal_bit();
      t_lin();
      t_no_restart();
      t_timer();
      t_clear_priority();
      t_zero_div();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(5.0 * 190000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule